// File: doc/BRIEF.md
# Role Swap Key Press Detector

This block turns a burst of deliberate presses on one active-low push-button into a request to swap the power role of a Type-C port. The design samples the button, which is already synchronized, on a fast clock. An outside timebase supplies a one-cycle `tick` enable, and the design measures every duration in ticks. A low level counts as a press only after it has lasted longer than a qualification time. Brief glitches are dropped. A sliding window opens at the first qualified press. When enough further presses land inside that window, the block issues a single-cycle `swap_req` and returns to idle with its press count cleared.

Beside the request, the block holds a sticky role-swap indication bit for a register interface. In host-controlled mode the button is ignored. Software then starts a swap by writing 1 to the indication bit, and writing 0 clears the bit in either mode.

The design is built from two state machines. The press qualifier has the states `K_UP` (button released), `K_TIMING` (button low, counting ticks) and `K_HELD` (press already counted, waiting for release). Its transitions are: UP→TIMING when the button goes low, TIMING→UP when the button is released early, TIMING→HELD on the qualifying tick, and HELD→UP on release. The window tracker has the states `W_IDLE`, `W_OPEN` and `W_FIRE`. Its transitions are: IDLE→OPEN on the first qualified press, OPEN→OPEN on further presses, OPEN→OPEN as a restart when a press lands on the expiry tick, OPEN→IDLE on expiry, OPEN→FIRE on the last press needed, and FIRE→IDLE unconditionally. Host mode forces both machines back to their idle states.

Top module: `rsk_role_swap_key`

## Requirements
- R1: A press qualifies only when `key_n` stays 0 for more than `PRESS_TICKS` ticks. Ticks are counted from the cycle after the low level is first seen, and a press qualifies on the (`PRESS_TICKS`+1)-th such tick. A release before that tick discards the press.
- R2: A qualified press is counted once. No further press is counted until `key_n` has returned to 1.
- R3: The window opens at the first qualified press and lasts `WINDOW_TICKS` ticks. When it expires before the target is reached, the count is discarded. A press that lands on the expiry tick starts a new window with a count of 1.
- R4: A swap fires when the `PRESS_NEED`-th qualified press falls inside one open window. The default value is 4, meaning more than three presses.
- R5: `swap_req` is high for exactly one cycle per swap, one clock after the firing state is entered. The press count clears when the swap fires, so later presses start a new window.
- R6: `swap_ind` is set in the same cycle that `swap_req` is high, and it stays set until a register write with `ind_wdata`=0. If a set and a clear arrive together, the set wins.
- R7: While `host_mode`=1, presses have no effect. A write of 1 (`ind_wr`=1, `ind_wdata`=1) produces one `swap_req` pulse and sets `swap_ind`. With `host_mode`=0, the same write has no effect.
- R8: After reset, `swap_req`=0, `swap_ind`=0 and no presses are counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase enable, one cycle per time unit |
| key_n | input | 1 | Synchronized push-button, 0 = pressed |
| host_mode | input | 1 | 1 = software starts swaps and the key is ignored |
| ind_wr | input | 1 | Write strobe for the indication bit |
| ind_wdata | input | 1 | Value written to the indication bit |
| swap_req | output | 1 | One-cycle role-swap request |
| swap_ind | output | 1 | Sticky role-swap indication bit |

## Verification
The bench holds the button low for exactly `PRESS_TICKS` ticks and for one tick more. A design with an off-by-one threshold would accept the short press or reject the long one. It spaces presses so that the fourth press lands after the window has closed. A tracker that never expires, or that restarts its timer on every press, would then fire a swap. It also holds each press far beyond the threshold, and it sends eight quick presses to show that one burst gives one swap and the next burst starts from zero. A qualifier that re-counts a held press, or a tracker that keeps its count after firing, would give extra swaps. Host-mode runs confirm that presses are ignored and that only a write of 1 in that mode pulses `swap_req` and sets the sticky bit.

// File: rtl/rsk_pkg.sv
package rsk_pkg;

    // Press qualifier states
    typedef enum logic [1:0] {
        K_UP     = 2'd0,
        K_TIMING = 2'd1,
        K_HELD   = 2'd2
    } key_state_e;

    // Window tracker states
    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_OPEN = 2'd1,
        W_FIRE = 2'd2
    } win_state_e;

endpackage

// File: rtl/rsk_press_qual.sv
module rsk_press_qual
    import rsk_pkg::*;
#(
    parameter int PRESS_TICKS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic key_n,
    input  logic hold,
    output logic press_ok
);
    localparam int CW = $clog2(PRESS_TICKS + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(PRESS_TICKS);

    key_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= K_UP;
        else        state_q <= state_d;
    end

    // Tick counter while the key is low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             cnt_q <= '0;
        else if (state_q != K_TIMING)           cnt_q <= '0;
        else if (tick && (cnt_q != CNT_LAST))   cnt_q <= cnt_q + 1'b1;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            K_UP:     if (!hold && !key_n) state_d = K_TIMING;
            K_TIMING: begin
                if (hold || key_n)                    state_d = K_UP;
                else if (tick && (cnt_q == CNT_LAST)) state_d = K_HELD;
            end
            K_HELD:   if (hold || key_n) state_d = K_UP;
            default:  state_d = K_UP;
        endcase
    end

    // Outputs: qualification happens on the TIMING -> HELD transition
    always_comb begin
        press_ok = (state_q == K_TIMING) && (state_d == K_HELD);
    end

    // R1: the key was already low in the cycle before qualification
    a_r1_low_before_ok: assert property (@(posedge clk) disable iff (!rst_n)
        press_ok |-> $past(!key_n));
    // R1: counter never passes the threshold
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);
    // R2: a press is never counted in two consecutive cycles
    a_r2_count_once: assert property (@(posedge clk) disable iff (!rst_n)
        press_ok |=> !press_ok);

endmodule

// File: rtl/rsk_window.sv
module rsk_window
    import rsk_pkg::*;
#(
    parameter int WINDOW_TICKS = 3000,
    parameter int PRESS_NEED   = 4     // must be at least 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold,
    input  logic press_ok,
    output logic fire
);
    localparam int TW = $clog2(WINDOW_TICKS + 1);
    localparam int PW = $clog2(PRESS_NEED + 1);
    localparam logic [TW-1:0] T_LAST = TW'(WINDOW_TICKS - 1);
    localparam logic [PW-1:0] P_LAST = PW'(PRESS_NEED - 1);

    win_state_e    state_q, state_d;
    logic [TW-1:0] timer_q;
    logic [PW-1:0] presses_q;
    logic          expire;

    always_comb expire = (state_q == W_OPEN) && tick && (timer_q == T_LAST);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= W_IDLE;
        else        state_q <= state_d;
    end

    // Window timer and press count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_q   <= '0;
            presses_q <= '0;
        end else begin
            unique case (state_q)
                W_IDLE: begin
                    timer_q   <= '0;
                    presses_q <= (press_ok && !hold) ? PW'(1) : '0;
                end
                W_OPEN: begin
                    if (hold) begin
                        timer_q   <= '0;
                        presses_q <= '0;
                    end else if (expire) begin
                        timer_q   <= '0;
                        presses_q <= press_ok ? PW'(1) : '0;
                    end else begin
                        if (tick)     timer_q   <= timer_q + 1'b1;
                        if (press_ok) presses_q <= presses_q + 1'b1;
                    end
                end
                default: begin
                    timer_q   <= '0;
                    presses_q <= '0;
                end
            endcase
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE: if (!hold && press_ok) state_d = W_OPEN;
            W_OPEN: begin
                if (hold)                                   state_d = W_IDLE;
                else if (expire)                            state_d = press_ok ? W_OPEN : W_IDLE;
                else if (press_ok && (presses_q == P_LAST)) state_d = W_FIRE;
            end
            W_FIRE:  state_d = W_IDLE;
            default: state_d = W_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        fire = (state_q == W_FIRE);
    end

    // R3: the timer stays inside the window
    a_r3_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        timer_q <= T_LAST);
    // R4: firing follows the last needed press
    a_r4_fire_on_need: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> ($past(presses_q) == P_LAST));
    // R5: firing lasts one cycle and clears the count
    a_r5_fire_single: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
    a_r5_fire_clears: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (presses_q == '0));

endmodule

// File: rtl/rsk_role_swap_key.sv
module rsk_role_swap_key #(
    parameter int PRESS_TICKS  = 32,
    parameter int WINDOW_TICKS = 3000,
    parameter int PRESS_NEED   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic key_n,
    input  logic host_mode,
    input  logic ind_wr,
    input  logic ind_wdata,
    output logic swap_req,
    output logic swap_ind
);
    logic press_ok;
    logic key_fire;
    logic host_go;
    logic swap_set;
    logic ind_clr;

    rsk_press_qual #(.PRESS_TICKS(PRESS_TICKS)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .key_n    (key_n),
        .hold     (host_mode),
        .press_ok (press_ok)
    );

    rsk_window #(.WINDOW_TICKS(WINDOW_TICKS), .PRESS_NEED(PRESS_NEED)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .hold     (host_mode),
        .press_ok (press_ok),
        .fire     (key_fire)
    );

    always_comb begin
        host_go  = host_mode && ind_wr && ind_wdata;
        swap_set = host_go || (!host_mode && key_fire);
        ind_clr  = ind_wr && !ind_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            swap_req <= 1'b0;
            swap_ind <= 1'b0;
        end else begin
            swap_req <= swap_set;
            if (swap_set)     swap_ind <= 1'b1;
            else if (ind_clr) swap_ind <= 1'b0;
        end
    end

    // R6: a request is always reflected in the indication bit
    a_r6_req_sets_ind: assert property (@(posedge clk) disable iff (!rst_n)
        swap_req |-> swap_ind);
    // R7: no key-driven firing while host mode is held
    a_r7_host_blocks_key: assert property (@(posedge clk) disable iff (!rst_n)
        (host_mode && $past(host_mode)) |-> !key_fire);

endmodule

// File: tb/rsk_role_swap_key_tb.sv
module rsk_role_swap_key_tb;
    localparam int PT   = 3;
    localparam int WT   = 40;
    localparam int NEED = 4;
    localparam int NV   = 8;

    // Vector table: hold ticks, gap ticks, press count, host mode, expected swaps
    localparam int V_LEN [NV] = '{4, 3, 4,  4, 4, 4, 4, 8};
    localparam int V_GAP [NV] = '{2, 2, 2, 12, 2, 2, 2, 1};
    localparam int V_CNT [NV] = '{4, 4, 3,  4, 8, 7, 4, 4};
    localparam int V_HOST[NV] = '{0, 0, 0,  0, 0, 0, 1, 0};
    localparam int V_EXP [NV] = '{1, 0, 0,  0, 2, 1, 0, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic key_n = 1'b1;
    logic host_mode = 1'b0;
    logic ind_wr = 1'b0;
    logic ind_wdata = 1'b0;
    logic swap_req;
    logic swap_ind;

    int checks = 0;
    int fails = 0;
    int pulses = 0;
    int wide = 0;
    int cycles = 0;
    logic prev_req = 1'b0;

    always #5 clk = ~clk;

    rsk_role_swap_key #(.PRESS_TICKS(PT), .WINDOW_TICKS(WT), .PRESS_NEED(NEED)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .key_n(key_n),
        .host_mode(host_mode), .ind_wr(ind_wr), .ind_wdata(ind_wdata),
        .swap_req(swap_req), .swap_ind(swap_ind)
    );

    // Pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (swap_req) pulses++;
        if (swap_req && prev_req) wide++;
        prev_req = swap_req;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            finish_run();
        end
    end

    // One timebase unit: a tick cycle followed by three quiet cycles
    task automatic unit(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic press(input int len, input int gap);
        key_n = 1'b0;
        @(negedge clk);
        unit(len);
        key_n = 1'b1;
        unit(gap);
    endtask

    task automatic reg_write(input logic v);
        ind_wr = 1'b1;
        ind_wdata = v;
        @(negedge clk);
        ind_wr = 1'b0;
        ind_wdata = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 swap_req at reset", int'(swap_req), 0);
        check("R8 swap_ind at reset", int'(swap_ind), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 swap_req after reset", int'(swap_req), 0);

        // Table-driven scenarios (R1 R2 R3 R4 R5 R6 R7)
        for (int v = 0; v < NV; v++) begin
            host_mode = (V_HOST[v] != 0);
            unit(WT + 10);
            reg_write(1'b0);
            pulses = 0;
            wide = 0;
            for (int p = 0; p < V_CNT[v]; p++) press(V_LEN[v], V_GAP[v]);
            unit(2);
            check($sformatf("R1 R2 R3 R4 vector %0d swaps", v), pulses, V_EXP[v]);
            check($sformatf("R5 vector %0d single-cycle", v), wide, 0);
            check($sformatf("R6 vector %0d indication", v), int'(swap_ind), (V_EXP[v] > 0) ? 1 : 0);
        end

        // R1: one-cycle glitches never qualify
        host_mode = 1'b0;
        unit(WT + 10);
        reg_write(1'b0);
        pulses = 0;
        for (int g = 0; g < 10; g++) begin
            key_n = 1'b0;
            tick = 1'b1;
            @(negedge clk);
            key_n = 1'b1;
            tick = 1'b0;
            @(negedge clk);
            unit(1);
        end
        check("R1 glitches ignored", pulses, 0);

        // R7: device-mode write of 1 has no effect
        pulses = 0;
        reg_write(1'b1);
        check("R7 device write pulses", pulses, 0);
        check("R7 device write indication", int'(swap_ind), 0);

        // R7: host-mode write of 1 gives one pulse and sets the bit
        host_mode = 1'b1;
        @(negedge clk);
        pulses = 0;
        wide = 0;
        ind_wr = 1'b1;
        ind_wdata = 1'b1;
        @(negedge clk);
        ind_wr = 1'b0;
        ind_wdata = 1'b0;
        check("R7 host write swap_req high", int'(swap_req), 1);
        @(negedge clk);
        check("R5 host write swap_req low next", int'(swap_req), 0);
        check("R7 host write pulse count", pulses, 1);
        check("R6 host write indication", int'(swap_ind), 1);

        // R6: indication stays set, then clears on write of 0
        unit(5);
        check("R6 indication sticky", int'(swap_ind), 1);
        reg_write(1'b0);
        check("R6 indication cleared", int'(swap_ind), 0);

        finish_run();
    end
endmodule